// File: doc/BRIEF.md
# Snoop Response Controller

This block sits beside a look-aside secondary cache and reacts to bus transactions started by masters other than the local processor. For each accepted snoop it takes the five-bit transfer type and the tag lookup result for the snooped address. From these it decides whether to leave the line alone, invalidate it, clear its dirty bit, or push the dirty line out first. A push begins with a one-cycle retry, which aborts the snooping master, and a bus request.

Once the retry window has passed, the controller looks at the processor's own bus request. If the processor wants the bus, the push is abandoned: the request drops in that same cycle and any grant is ignored. Otherwise the controller holds its request until the grant arrives. It then marks the push active until the data path reports completion, and only then issues the tag update.

The controller also keeps a one-entry record of the most recent snoop: whether it was a read or a write, and whether it hit. When a processor burst write comes in, the controller gives the processor-side logic a piece of advice taken from that record. Any processor transaction clears the record.

Top module: `snp_resp_ctrl`

## Requirements
- R1: Transfer types `00100`, `x0010` and `x1110` belong to the flush group. The leftmost digit is `snp_tt[4]` and `x` means either value. On a clean hit they put tag op 1 (invalidate) on `tag_op_o` for one cycle, in the cycle after the snoop, with no retry and no bus request.
- R2: A flush-group snoop that hits a dirty line raises `retry_o` for exactly one cycle, in the cycle after the snoop. `bus_req_o` is high in that same cycle. When the push completes, tag op 1 is issued.
- R3: Transfer types `00000` and `x1010` belong to the clean group. On a clean hit they produce no retry, no bus request and tag op 0 (none).
- R4: A clean-group snoop that hits a dirty line pushes the line in the same way as R2. When the push completes, tag op 2 (clear dirty) is issued.
- R5: Transfer types `0110x` and `00110` belong to the kill group. On any hit, clean or dirty, they issue tag op 1 in the cycle after the snoop and never retry.
- R6: A snoop that misses produces no retry, no bus request and tag op 0. So does a hit with a transfer type outside the three groups.
- R7: In the cycle after the retry window, `cpu_breq` is sampled. If it is high, `bus_req_o` is low in that cycle and any grant is ignored. No push and no tag op follow, and the block accepts snoops again on the next cycle.
- R8: If `cpu_breq` is low in that cycle, `bus_req_o` stays high until `l2_grant` is seen. `push_active_o` is high from the cycle after the grant until the cycle in which `push_done` is sampled. The tag op follows one cycle later.
- R9: When `cpu_txn_valid` and `cpu_burst_wr` are both high, `wr_advice_o` is derived from the stored snoop record, where `snp_tt[3]`=1 marks a read:
  - a write that hit gives 1 (invalidate);
  - a write that missed gives 3 (no allocate);
  - a read that hit gives 2 (update and clear dirty);
  - a read that missed, or no record at all, gives 0 (normal).
- R10: Any processor transaction clears the record. If a snoop is accepted in the same cycle, the advice in that cycle comes from the old record and the new snoop is the one stored.
- R11: A snoop that arrives while a push sequence is in progress is ignored. It causes no retry and no tag op, and it does not alter the record.
- R12: After reset, `retry_o`, `bus_req_o` and `push_active_o` are 0, and `tag_op_o` and `wr_advice_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snp_valid | input | 1 | Snooped transfer start, one cycle |
| snp_tt | input | 5 | Transfer type of the snooped transaction |
| snp_hit | input | 1 | Tag lookup hit on a valid line |
| snp_dirty | input | 1 | Hit line is dirty |
| cpu_breq | input | 1 | Processor bus request |
| l2_grant | input | 1 | Bus grant for this block |
| push_done | input | 1 | Write-back data transfer finished |
| cpu_txn_valid | input | 1 | Processor-side transaction, one cycle |
| cpu_burst_wr | input | 1 | That transaction is a burst write |
| retry_o | output | 1 | Retry to the snooping master |
| bus_req_o | output | 1 | Bus request for the push |
| push_active_o | output | 1 | Push owns the bus |
| tag_op_o | output | 2 | Tag command: 0 none, 1 invalidate, 2 clear dirty |
| wr_advice_o | output | 2 | Burst write advice per R9 |

## Verification
Two functions can fall in the same cycle. One is a snoop acceptance, which writes the one-entry record. The other is a processor transaction, which reads the record and clears it. The bench provokes this by driving `snp_valid` and `cpu_txn_valid` together. It then judges the combinational advice in that cycle against the old record, and the advice of the next burst write against the new snoop. A second overlap is provoked by asserting `cpu_breq` and `l2_grant` together in the sample cycle after a retry. There the grant must lose: the bench expects no push and no tag op.

// File: rtl/snp_pkg.sv
package snp_pkg;
    localparam int TT_W = 5;

    typedef enum logic [1:0] {
        TAG_NOP       = 2'd0,
        TAG_INVAL     = 2'd1,
        TAG_CLR_DIRTY = 2'd2
    } tag_op_e;

    typedef enum logic [1:0] {
        ADV_NORMAL    = 2'd0,
        ADV_INVAL     = 2'd1,
        ADV_UPD_CLEAN = 2'd2,
        ADV_NO_ALLOC  = 2'd3
    } wr_adv_e;

    typedef enum logic [2:0] {
        PS_IDLE, PS_RETRY, PS_SAMPLE, PS_WAITG, PS_PUSH
    } push_st_e;

    typedef struct packed {
        logic    push;
        tag_op_e op;
    } snp_act_t;

    typedef struct packed {
        logic valid;
        logic rd;
        logic hit;
    } snp_rec_t;

    function automatic wr_adv_e advice_of(snp_rec_t r);
        if (!r.valid)
            return ADV_NORMAL;
        if (r.rd)
            return r.hit ? ADV_UPD_CLEAN : ADV_NORMAL;
        return r.hit ? ADV_INVAL : ADV_NO_ALLOC;
    endfunction
endpackage

// File: rtl/snp_decode.sv
module snp_decode
    import snp_pkg::*;
(
    input  logic [TT_W-1:0] tt,
    input  logic            hit,
    input  logic            dirty,
    output snp_act_t        act
);
    logic grp_flush, grp_clean, grp_kill;

    always_comb begin
        grp_flush = (tt == 5'b00100) || (tt[3:0] == 4'b0010) || (tt[3:0] == 4'b1110);
        grp_clean = (tt == 5'b00000) || (tt[3:0] == 4'b1010);
        grp_kill  = (tt[4:1] == 4'b0110) || (tt == 5'b00110);
    end

    always_comb begin
        act = '{push: 1'b0, op: TAG_NOP};
        if (hit) begin
            if (grp_kill)
                act = '{push: 1'b0, op: TAG_INVAL};
            else if (grp_flush)
                act = '{push: dirty, op: TAG_INVAL};
            else if (grp_clean)
                act = '{push: dirty, op: dirty ? TAG_CLR_DIRTY : TAG_NOP};
        end
    end

    // R1/R5: a kill or flush hit never asks for clear-dirty
    always_comb begin
        if (hit && (grp_kill || grp_flush))
            a_no_clr_r5: assert (act.op != TAG_CLR_DIRTY);
    end
endmodule

// File: rtl/snp_record.sv
module snp_record
    import snp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    snp_fire,
    input  logic    snp_rd,
    input  logic    snp_hit,
    input  logic    cpu_txn_valid,
    input  logic    cpu_burst_wr,
    output wr_adv_e advice
);
    snp_rec_t rec_q;

    always_ff @(posedge clk) begin
        if (rst)
            rec_q <= '0;
        else if (snp_fire)
            rec_q <= '{valid: 1'b1, rd: snp_rd, hit: snp_hit};
        else if (cpu_txn_valid)
            rec_q <= '0;
    end

    always_comb begin
        advice = ADV_NORMAL;
        if (cpu_txn_valid && cpu_burst_wr)
            advice = advice_of(rec_q);
    end

    // R10: a processor transaction without a new snoop leaves nothing to advise
    p_consume_clears_r10: assert property (@(posedge clk) disable iff (rst)
        (cpu_txn_valid && !snp_fire) |=> (advice == ADV_NORMAL));
    // R9: advice is only given to a burst write
    p_adv_only_burst_r9: assert property (@(posedge clk) disable iff (rst)
        (advice != ADV_NORMAL) |-> (cpu_txn_valid && cpu_burst_wr));
endmodule

// File: rtl/snp_push_fsm.sv
module snp_push_fsm
    import snp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  tag_op_e start_op,
    input  logic    direct,
    input  tag_op_e direct_op,
    input  logic    cpu_breq,
    input  logic    grant,
    input  logic    push_done,
    output logic    idle,
    output logic    retry,
    output logic    bus_req,
    output logic    push_active,
    output tag_op_e tag_op
);
    push_st_e st_q;
    tag_op_e  kind_q;
    tag_op_e  op_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= PS_IDLE;
            kind_q <= TAG_NOP;
            op_q   <= TAG_NOP;
        end else begin
            op_q <= TAG_NOP;
            case (st_q)
                PS_IDLE: begin
                    if (start) begin
                        st_q   <= PS_RETRY;
                        kind_q <= start_op;
                    end else if (direct) begin
                        op_q <= direct_op;
                    end
                end
                PS_RETRY:  st_q <= PS_SAMPLE;
                PS_SAMPLE: begin
                    if (cpu_breq)   st_q <= PS_IDLE;
                    else if (grant) st_q <= PS_PUSH;
                    else            st_q <= PS_WAITG;
                end
                PS_WAITG: if (grant) st_q <= PS_PUSH;
                PS_PUSH: begin
                    if (push_done) begin
                        op_q <= kind_q;
                        st_q <= PS_IDLE;
                    end
                end
                default: st_q <= PS_IDLE;
            endcase
        end
    end

    always_comb begin
        idle        = (st_q == PS_IDLE);
        retry       = (st_q == PS_RETRY);
        bus_req     = (st_q == PS_RETRY) || (st_q == PS_WAITG) ||
                      ((st_q == PS_SAMPLE) && !cpu_breq);
        push_active = (st_q == PS_PUSH);
        tag_op      = op_q;
    end

    // R2: retry follows an accepted dirty snoop by one clock
    p_retry_next_r2: assert property (@(posedge clk) disable iff (rst)
        (idle && start) |=> (retry && bus_req));
    // R2: the retry window is a single cycle
    p_retry_single_r2: assert property (@(posedge clk) disable iff (rst)
        retry |=> !retry);
    // R7: processor request in the sample cycle abandons the push
    p_yield_r7: assert property (@(posedge clk) disable iff (rst)
        ((st_q == PS_SAMPLE) && cpu_breq) |=> (!push_active && !bus_req && tag_op == TAG_NOP));
    // R8: the bus is only taken after it was requested
    p_push_after_req_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(push_active) |-> $past(bus_req));
endmodule

// File: rtl/snp_resp_ctrl.sv
module snp_resp_ctrl
    import snp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            snp_valid,
    input  logic [TT_W-1:0] snp_tt,
    input  logic            snp_hit,
    input  logic            snp_dirty,
    input  logic            cpu_breq,
    input  logic            l2_grant,
    input  logic            push_done,
    input  logic            cpu_txn_valid,
    input  logic            cpu_burst_wr,
    output logic            retry_o,
    output logic            bus_req_o,
    output logic            push_active_o,
    output logic [1:0]      tag_op_o,
    output logic [1:0]      wr_advice_o
);
    localparam int RD_BIT = TT_W - 2;

    snp_act_t act;
    logic     idle, snp_fire;
    tag_op_e  tag_op;
    wr_adv_e  advice;

    assign snp_fire = snp_valid && idle;

    snp_decode dec_i (
        .tt    (snp_tt),
        .hit   (snp_hit),
        .dirty (snp_dirty),
        .act   (act)
    );

    snp_push_fsm fsm_i (
        .clk         (clk),
        .rst         (rst),
        .start       (snp_fire && act.push),
        .start_op    (act.op),
        .direct      (snp_fire && !act.push),
        .direct_op   (act.op),
        .cpu_breq    (cpu_breq),
        .grant       (l2_grant),
        .push_done   (push_done),
        .idle        (idle),
        .retry       (retry_o),
        .bus_req     (bus_req_o),
        .push_active (push_active_o),
        .tag_op      (tag_op)
    );

    snp_record rec_i (
        .clk           (clk),
        .rst           (rst),
        .snp_fire      (snp_fire),
        .snp_rd        (snp_tt[RD_BIT]),
        .snp_hit       (snp_hit),
        .cpu_txn_valid (cpu_txn_valid),
        .cpu_burst_wr  (cpu_burst_wr),
        .advice        (advice)
    );

    assign tag_op_o    = tag_op;
    assign wr_advice_o = advice;

    // R6: a missed snoop changes nothing visible
    p_miss_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (snp_fire && !snp_hit) |=> (!retry_o && tag_op_o == TAG_NOP));
    // R11: a snoop during a push sequence draws no retry
    p_busy_ignore_r11: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && !idle && !push_active_o) |=> !retry_o);
endmodule

// File: tb/snp_resp_ctrl_tb_top.sv
`timescale 1ns/1ps
module snp_resp_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst;
    logic snp_valid, snp_hit, snp_dirty, cpu_breq, l2_grant, push_done;
    logic cpu_txn_valid, cpu_burst_wr;
    logic [4:0] snp_tt;
    logic retry_o, bus_req_o, push_active_o;
    logic [1:0] tag_op_o, wr_advice_o;
    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    snp_resp_ctrl dut_i (
        .clk(clk), .rst(rst), .snp_valid(snp_valid), .snp_tt(snp_tt),
        .snp_hit(snp_hit), .snp_dirty(snp_dirty), .cpu_breq(cpu_breq),
        .l2_grant(l2_grant), .push_done(push_done), .cpu_txn_valid(cpu_txn_valid),
        .cpu_burst_wr(cpu_burst_wr), .retry_o(retry_o), .bus_req_o(bus_req_o),
        .push_active_o(push_active_o), .tag_op_o(tag_op_o), .wr_advice_o(wr_advice_o)
    );

    typedef struct packed {
        logic [4:0] tt;
        logic       hit;
        logic       dirty;
        logic       push;
        logic [1:0] op;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{5'b00100, 1'b1, 1'b0, 1'b0, 2'd1, 4'd1},  // R1
        '{5'b10010, 1'b1, 1'b0, 1'b0, 2'd1, 4'd1},  // R1
        '{5'b01110, 1'b1, 1'b0, 1'b0, 2'd1, 4'd1},  // R1
        '{5'b00000, 1'b1, 1'b0, 1'b0, 2'd0, 4'd3},  // R3
        '{5'b11010, 1'b1, 1'b0, 1'b0, 2'd0, 4'd3},  // R3
        '{5'b01100, 1'b1, 1'b1, 1'b0, 2'd1, 4'd5},  // R5
        '{5'b01101, 1'b1, 1'b0, 1'b0, 2'd1, 4'd5},  // R5
        '{5'b00110, 1'b1, 1'b1, 1'b0, 2'd1, 4'd5},  // R5
        '{5'b00100, 1'b0, 1'b1, 1'b0, 2'd0, 4'd6},  // R6
        '{5'b10100, 1'b1, 1'b1, 1'b0, 2'd0, 4'd6},  // R6
        '{5'b00010, 1'b1, 1'b1, 1'b1, 2'd1, 4'd2},  // R2
        '{5'b11110, 1'b1, 1'b1, 1'b1, 2'd1, 4'd2},  // R2
        '{5'b00000, 1'b1, 1'b1, 1'b1, 2'd2, 4'd4},  // R4
        '{5'b01010, 1'b1, 1'b1, 1'b1, 2'd2, 4'd4},  // R4
        '{5'b11010, 1'b1, 1'b1, 1'b1, 2'd2, 4'd4}   // R4
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one-cycle snoop; returns at the negedge after the capturing edge
    task automatic snoop(input logic [4:0] tt, input logic h, input logic d);
        @(negedge clk);
        snp_valid = 1'b1; snp_tt = tt; snp_hit = h; snp_dirty = d;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    // called at the negedge where the FSM sits in the retry cycle
    task automatic finish_push(input string req, input int exp_op);
        cpu_breq = 1'b0;
        @(negedge clk);                 // sample cycle
        chk({req, " bus_req in sample"}, int'(bus_req_o), 1);
        l2_grant = 1'b1;
        @(negedge clk);                 // push cycle
        l2_grant = 1'b0;
        chk({req, " push_active after grant (R8)"}, int'(push_active_o), 1);
        chk({req, " bus_req dropped (R8)"}, int'(bus_req_o), 0);
        push_done = 1'b1;
        @(negedge clk);
        push_done = 1'b0;
        chk({req, " tag op after push (R8)"}, int'(tag_op_o), exp_op);
        chk({req, " push_active cleared"}, int'(push_active_o), 0);
    endtask

    task automatic cpu_txn(input logic burst, input int exp_adv, input string req);
        @(negedge clk);
        cpu_txn_valid = 1'b1; cpu_burst_wr = burst;
        #1;
        chk(req, int'(wr_advice_o), exp_adv);
        @(negedge clk);
        cpu_txn_valid = 1'b0; cpu_burst_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; snp_valid = 0; snp_tt = '0; snp_hit = 0; snp_dirty = 0;
        cpu_breq = 0; l2_grant = 0; push_done = 0; cpu_txn_valid = 0; cpu_burst_wr = 0;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 retry", int'(retry_o), 0);
        chk("R12 bus_req", int'(bus_req_o), 0);
        chk("R12 push_active", int'(push_active_o), 0);
        chk("R12 tag_op", int'(tag_op_o), 0);
        chk("R12 advice", int'(wr_advice_o), 0);
        rst = 1'b0;

        // table walk
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            snoop(VECS[i].tt, VECS[i].hit, VECS[i].dirty);
            chk({tag, " retry"}, int'(retry_o), int'(VECS[i].push));
            chk({tag, " bus_req"}, int'(bus_req_o), int'(VECS[i].push));
            chk({tag, " direct tag op"}, int'(tag_op_o), VECS[i].push ? 0 : int'(VECS[i].op));
            if (VECS[i].push) begin
                finish_push(tag, int'(VECS[i].op));
            end
            @(negedge clk);
            chk({tag, " tag op single pulse"}, int'(tag_op_o), 0);
        end

        // R7: processor request in sample cycle, grant offered at the same time
        snoop(5'b00100, 1'b1, 1'b1);
        chk("R2 retry before yield", int'(retry_o), 1);
        cpu_breq = 1'b1; l2_grant = 1'b1;
        @(negedge clk);
        chk("R7 bus_req negated at once", int'(bus_req_o), 0);
        chk("R7 retry gone", int'(retry_o), 0);
        @(negedge clk);
        chk("R7 grant ignored", int'(push_active_o), 0);
        chk("R7 no tag op", int'(tag_op_o), 0);
        cpu_breq = 1'b0; l2_grant = 1'b0;
        snoop(5'b01100, 1'b1, 1'b0);
        chk("R7 accepts snoops again", int'(tag_op_o), 1);

        // R8: grant delayed several cycles
        snoop(5'b00000, 1'b1, 1'b1);
        @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R8 request held while waiting", int'(bus_req_o), 1);
        chk("R8 not active before grant", int'(push_active_o), 0);
        // R11: snoop while waiting for grant is ignored (kill hit, then record check)
        snoop(5'b01100, 1'b1, 1'b0);
        chk("R11 no tag op from busy snoop", int'(tag_op_o), 0);
        chk("R11 no retry from busy snoop", int'(retry_o), 0);
        l2_grant = 1'b1;
        @(negedge clk);
        l2_grant = 1'b0;
        chk("R8 active after late grant", int'(push_active_o), 1);
        repeat (2) @(negedge clk);
        chk("R8 active until done", int'(push_active_o), 1);
        push_done = 1'b1;
        @(negedge clk);
        push_done = 1'b0;
        chk("R8 clear dirty after push", int'(tag_op_o), 2);
        // record still from the write-hit 00000 snoop, not the ignored read
        cpu_txn(1'b1, 1, "R11 record untouched by busy snoop");

        // R9 advice encodings
        cpu_txn(1'b1, 0, "R9 no record gives normal");
        snoop(5'b00000, 1'b1, 1'b0);
        cpu_txn(1'b1, 1, "R9 write hit gives invalidate");
        snoop(5'b01010, 1'b1, 1'b0);
        cpu_txn(1'b1, 2, "R9 read hit gives update clean");
        snoop(5'b00100, 1'b0, 1'b0);
        cpu_txn(1'b1, 3, "R9 write miss gives no allocate");
        snoop(5'b01110, 1'b0, 1'b0);
        cpu_txn(1'b1, 0, "R9 read miss gives normal");

        // R10: non-burst transaction consumes the record
        snoop(5'b00000, 1'b1, 1'b0);
        cpu_txn(1'b0, 0, "R10 non-burst advice");
        cpu_txn(1'b1, 0, "R10 record cleared by any transaction");

        // R10: same-cycle snoop and processor transaction
        snoop(5'b00000, 1'b1, 1'b0);
        @(negedge clk);
        snp_valid = 1'b1; snp_tt = 5'b01010; snp_hit = 1'b1; snp_dirty = 1'b0;
        cpu_txn_valid = 1'b1; cpu_burst_wr = 1'b1;
        #1;
        chk("R10 advice from old record", int'(wr_advice_o), 1);
        @(negedge clk);
        snp_valid = 1'b0; cpu_txn_valid = 1'b0; cpu_burst_wr = 1'b0;
        cpu_txn(1'b1, 2, "R10 new snoop stored");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule